// File: doc/BRIEF.md
# Over-Clock Watchdog with Safe-Frequency Fallback

This block protects a clock generator from an over-clocked setting that leaves the system hung. The host sets a timeout in coarse units and arms the watchdog. Each host write to either of the block's two registers counts as a check-in and restarts the interval. If the interval runs out without a check-in, the block latches an alarm. It then replaces the normal 5-bit frequency selection with a safe code that the host stored ahead of time. The safe code stays in force until the host clears the alarm.

Time is measured with a prescaled `tick` strobe. One timeout unit equals `UNIT_TICKS` ticks. With a 1 ms tick and a unit of 290 ticks, the reset timeout of 16 units gives about 4.6 s. A simulation can use a much shorter unit. The control register also holds a divider-mode bit, which is passed straight to the clock synthesizer. That bit chooses between the table-driven frequency and direct divider programming.

Top module: `ocw_fallback`

## Requirements
- R1: After reset the timeout register reads 16 and the control register reads 0. `act_sel` equals `norm_sel`, and both `safe_active` and `div_mode` are 0.
- R2: While the enable bit (control bit 6) is 0, no number of ticks raises the alarm.
- R3: When enabled with timeout N ≥ 1 and no host write, the alarm is set on tick number N·UNIT_TICKS, and not on an earlier tick. It is visible in the cycle after that tick is sampled.
- R4: While the alarm is set, `act_sel` equals the safe code in control bits 4:0 and `safe_active` is 1. Otherwise `act_sel` follows `norm_sel`, even when `norm_sel` changes.
- R5: Any host write (address 0 = timeout, address 1 = control) restarts the full interval. A write in the same cycle as the terminal tick wins, so no alarm is raised by that tick.
- R6: The alarm flag (control bit 5) is sticky. Ticks never clear it. A control write with bit 5 = 1 keeps it set, and only a control write with bit 5 = 0 clears it. A host write can never set it.
- R7: With timeout 0 and the watchdog enabled, the first tick raises the alarm.
- R8: `div_mode` equals control bit 7.
- R9: `rd_data` returns the timeout register for `rd_addr` = 0. For `rd_addr` = 1 it returns the control register {div mode, enable, alarm, safe code}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timebase strobe, one cycle wide |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | Write target: 0 timeout, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read target: 0 timeout, 1 control |
| rd_data | output | 8 | Read data |
| norm_sel | input | 5 | Normal frequency selection |
| act_sel | output | 5 | Frequency selection in force |
| safe_active | output | 1 | High while the safe code is selected |
| div_mode | output | 1 | Divider-programming mode select (control bit 7) |

## Verification
The hardest case to reach from the ports is a host write and the terminal tick landing in the same clock cycle. The bench drives both strobes on one falling edge, so the rising edge samples them together. It then confirms that no alarm was raised and that a complete fresh interval follows. The exact expiry tick is also hard to pin down. The bench checks it by stopping one tick short of N·UNIT_TICKS and then stepping a single tick.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
   localparam int REG_W  = 8;
   localparam int CODE_W = 5;

   typedef enum logic {
      ADDR_TIMEOUT = 1'b0,
      ADDR_CTRL    = 1'b1
   } ocw_addr_e;

   typedef struct packed {
      logic              div_mode;
      logic              wd_en;
      logic              alarm;
      logic [CODE_W-1:0] safe_code;
   } ocw_ctrl_t;
endpackage

// File: rtl/ocw_regs.sv
module ocw_regs
   import ocw_pkg::*;
#(
   parameter int          DATA_W      = 8,
   parameter logic [7:0]  TIMEOUT_RST = 8'd16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              expire,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] timeout_q,
   output ocw_ctrl_t         ctrl_q
);
   localparam int ALARM_BIT = CODE_W;

   if (DATA_W != REG_W) begin : g_bad_width
      $error("ocw_regs: DATA_W must equal the packed control width");
   end

   logic wr_timeout;
   logic wr_ctrl;

   assign wr_timeout = wr_en && (wr_addr == ADDR_TIMEOUT);
   assign wr_ctrl    = wr_en && (wr_addr == ADDR_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         timeout_q <= TIMEOUT_RST;
      end else if (wr_timeout) begin
         timeout_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.div_mode  <= wr_data[DATA_W-1];
         ctrl_q.wd_en     <= wr_data[DATA_W-2];
         ctrl_q.alarm     <= ctrl_q.alarm & wr_data[ALARM_BIT];
         ctrl_q.safe_code <= wr_data[CODE_W-1:0];
      end else if (expire) begin
         ctrl_q.alarm <= 1'b1;
      end
   end

   always_comb begin
      if (rd_addr == ADDR_CTRL) begin
         rd_data = ctrl_q;
      end else begin
         rd_data = timeout_q;
      end
   end

   // R6
   alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.alarm && !(wr_ctrl && !wr_data[ALARM_BIT])) |=> ctrl_q.alarm);

   // R6
   alarm_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_q.alarm) |-> $past(expire));
endmodule

// File: rtl/ocw_timer.sv
module ocw_timer #(
   parameter int          CNT_W       = 8,
   parameter int          UNIT_TICKS  = 290,
   parameter logic [7:0]  TIMEOUT_RST = 8'd16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             enable,
   input  logic             hold,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);
   localparam int              SUB_W    = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_TICKS - 1);
   localparam logic [CNT_W-1:0] ONE_UNIT = CNT_W'(1);

   if (UNIT_TICKS < 1) begin : g_bad_unit
      $error("ocw_timer: UNIT_TICKS must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ocw_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] units_left;
   logic [SUB_W-1:0] sub_cnt;
   logic             unit_done;
   logic             terminal;
   logic             advance;

   assign unit_done = (sub_cnt == SUB_LAST);
   assign terminal  = (units_left == '0) || ((units_left == ONE_UNIT) && unit_done);
   assign advance   = tick && enable && !hold && !reload;
   assign expire    = advance && terminal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         units_left <= CNT_W'(TIMEOUT_RST);
         sub_cnt    <= '0;
      end else if (reload) begin
         units_left <= load_val;
         sub_cnt    <= '0;
      end else if (advance && !terminal) begin
         if (unit_done) begin
            sub_cnt    <= '0;
            units_left <= units_left - ONE_UNIT;
         end else begin
            sub_cnt <= sub_cnt + SUB_W'(1);
         end
      end
   end

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !reload) |=> ($stable(units_left) && $stable(sub_cnt)));

   // R3
   expire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (tick && enable));

   // R5
   reload_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> ((units_left == $past(load_val)) && (sub_cnt == '0)));

   // R5
   reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> !expire);
endmodule

// File: rtl/ocw_select.sv
module ocw_select #(
   parameter int CODE_W  = 5,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              use_safe,
   input  logic [CODE_W-1:0] norm_sel,
   input  logic [CODE_W-1:0] safe_code,
   output logic [CODE_W-1:0] act_sel,
   output logic              safe_active
);
   logic [CODE_W-1:0] pick;

   assign pick = use_safe ? safe_code : norm_sel;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_sel     <= '0;
            safe_active <= 1'b0;
         end else begin
            act_sel     <= pick;
            safe_active <= use_safe;
         end
      end
   end else begin : g_comb
      assign act_sel     = pick;
      assign safe_active = use_safe;
   end
endmodule

// File: rtl/ocw_fallback.sv
module ocw_fallback
   import ocw_pkg::*;
#(
   parameter int          UNIT_TICKS  = 290,
   parameter logic [7:0]  TIMEOUT_RST = 8'd16,
   parameter bit          REG_OUT     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic [CODE_W-1:0] norm_sel,
   output logic [CODE_W-1:0] act_sel,
   output logic              safe_active,
   output logic              div_mode
);
   logic [REG_W-1:0] timeout_q;
   ocw_ctrl_t        ctrl_q;
   logic             expire;
   logic [REG_W-1:0] load_val;

   assign load_val = (wr_en && (wr_addr == ADDR_TIMEOUT)) ? wr_data : timeout_q;
   assign div_mode = ctrl_q.div_mode;

   ocw_regs #(
      .DATA_W      (REG_W),
      .TIMEOUT_RST (TIMEOUT_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .expire    (expire),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .timeout_q (timeout_q),
      .ctrl_q    (ctrl_q)
   );

   ocw_timer #(
      .CNT_W       (REG_W),
      .UNIT_TICKS  (UNIT_TICKS),
      .TIMEOUT_RST (TIMEOUT_RST)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .enable   (ctrl_q.wd_en),
      .hold     (ctrl_q.alarm),
      .reload   (wr_en),
      .load_val (load_val),
      .expire   (expire)
   );

   ocw_select #(
      .CODE_W  (CODE_W),
      .REG_OUT (REG_OUT)
   ) u_select (
      .clk         (clk),
      .rst_n       (rst_n),
      .use_safe    (ctrl_q.alarm),
      .norm_sel    (norm_sel),
      .safe_code   (ctrl_q.safe_code),
      .act_sel     (act_sel),
      .safe_active (safe_active)
   );

   if (!REG_OUT) begin : g_sel_chk
      // R4
      safe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_q.alarm |-> (act_sel == rd_data[CODE_W-1:0]) || (rd_addr == ADDR_TIMEOUT));
   end

   // R8
   div_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == ADDR_CTRL)) |=> (div_mode == $past(wr_data[REG_W-1])));
endmodule

// File: tb/ocw_fallback_test.sv
module ocw_fallback_test;
   localparam int UNIT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic [4:0] norm_sel = 5'h1A;
   logic [4:0] act_sel;
   logic       safe_active;
   logic       div_mode;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ocw_fallback #(.UNIT_TICKS(UNIT), .TIMEOUT_RST(8'd16)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .norm_sel(norm_sel),
      .act_sel(act_sel), .safe_active(safe_active), .div_mode(div_mode)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(1'b0, v); chk("R1 timeout reset", v, 8'd16);
      rd(1'b1, v); chk("R1 ctrl reset", v, 8'h00);
      chk("R1 act_sel", {3'b0, act_sel}, {3'b0, norm_sel});
      chk("R1 safe_active", {7'b0, safe_active}, 8'h0);
      chk("R1 div_mode", {7'b0, div_mode}, 8'h0);
   endtask

   task automatic t_disabled;
      logic [7:0] v;
      ticks(200);
      rd(1'b1, v); chk("R2 no alarm while disabled", v, 8'h00);
      chk("R2 act_sel normal", {3'b0, act_sel}, 8'h1A);
   endtask

   task automatic t_expiry;
      logic [7:0] v;
      wr(1'b0, 8'd3);
      wr(1'b1, 8'h45);
      ticks(3 * UNIT - 1);
      rd(1'b1, v); chk("R3 no alarm before last tick", v, 8'h45);
      ticks(1);
      rd(1'b1, v); chk("R3 R9 alarm on last tick", v, 8'h65);
      chk("R4 safe code in force", {3'b0, act_sel}, 8'h05);
      chk("R4 safe_active", {7'b0, safe_active}, 8'h1);
   endtask

   task automatic t_sticky;
      logic [7:0] v;
      ticks(50);
      rd(1'b1, v); chk("R6 alarm held by ticks", v, 8'h65);
      wr(1'b1, 8'h65);
      rd(1'b1, v); chk("R6 writing 1 keeps alarm", v, 8'h65);
      norm_sel = 5'h13;
      #1 chk("R4 ignores norm_sel in alarm", {3'b0, act_sel}, 8'h05);
      wr(1'b1, 8'h45);
      rd(1'b1, v); chk("R6 cleared by writing 0", v, 8'h45);
      chk("R4 normal after clear", {3'b0, act_sel}, 8'h13);
      wr(1'b1, 8'h05);
      wr(1'b1, 8'h25);
      rd(1'b1, v); chk("R6 write cannot set alarm", v, 8'h05);
   endtask

   task automatic t_reload;
      logic [7:0] v;
      wr(1'b1, 8'h45);
      ticks(10);
      wr(1'b0, 8'd3);
      ticks(3 * UNIT - 1);
      rd(1'b1, v); chk("R5 write restarted interval", v, 8'h45);
      ticks(1);
      rd(1'b1, v); chk("R5 expiry after full interval", v, 8'h65);
      wr(1'b1, 8'h45);
      ticks(3 * UNIT - 1);
      wr(1'b1, 8'h45);
      ticks(1);
      rd(1'b1, v); chk("R5 control write reloads", v, 8'h45);
   endtask

   task automatic t_collide;
      logic [7:0] v;
      wr(1'b0, 8'd1);
      wr(1'b1, 8'h45);
      ticks(UNIT - 1);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h45;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      rd(1'b1, v); chk("R5 write beats terminal tick", v, 8'h45);
      ticks(UNIT - 1);
      rd(1'b1, v); chk("R5 fresh interval running", v, 8'h45);
      ticks(1);
      rd(1'b1, v); chk("R5 expiry after fresh interval", v, 8'h65);
   endtask

   task automatic t_zero;
      logic [7:0] v;
      wr(1'b1, 8'h0A);
      wr(1'b0, 8'd0);
      wr(1'b1, 8'h4A);
      rd(1'b1, v); chk("R7 armed, no alarm yet", v, 8'h4A);
      ticks(1);
      rd(1'b1, v); chk("R7 first tick expires", v, 8'h6A);
      chk("R7 R4 safe code", {3'b0, act_sel}, 8'h0A);
      wr(1'b1, 8'h0A);
   endtask

   task automatic t_div;
      logic [7:0] v;
      wr(1'b1, 8'h80);
      chk("R8 div_mode set", {7'b0, div_mode}, 8'h1);
      rd(1'b1, v); chk("R8 R9 ctrl readback", v, 8'h80);
      rd(1'b0, v); chk("R9 timeout readback", v, 8'h00);
      wr(1'b1, 8'h00);
      chk("R8 div_mode clear", {7'b0, div_mode}, 8'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_disabled;
      t_expiry;
      t_sticky;
      t_reload;
      t_collide;
      t_zero;
      t_div;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule